// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small synchronous memory. Reads and writes can follow each other on every clock with no idle cycle between them. On each enabled rising edge it captures an operation: the address, the direction, the byte-lane enables and the three chip-select pins. The operation then passes through a fixed two-stage pipeline. Write data is taken from the data bus two enabled edges after the address. Read data is presented two enabled edges after the address. Because the two phases have the same spacing, the data bus never has to sit idle while it changes direction.

A load cycle starts a new access. An advance cycle continues the previous access as a burst. The two low address bits form a counter that wraps inside an aligned group of four words. A clock-enable input stalls the whole pipeline. A sleep input freezes the block and ignores every other input, and the stored contents are kept. An asynchronous output enable gates only the read data pins.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted, and after it is released until the first read completes, `rvalid` is 0 and `rdata` is all zeros.
- R2: A selected read loaded at an enabled edge drives `rvalid`=1 and the word on `rdata` right after the second later enabled edge, with `oe_n` low.
- R3: A selected write loaded at an enabled edge stores the `wdata` present at the second later enabled edge.
- R4: `bw_n` is active low. Bit i enables lane `wdata[i*9 +: 9]`. It is captured on the load cycle and reused for every advance cycle of that burst. Lanes that are not enabled keep their old contents.
- R5: An access is selected only if `cs_n_a`=0, `cs_n_b`=0 and `cs_h`=1 on its load cycle. A deselected access writes nothing and gives `rvalid`=0 and `rdata`=0. The select pins are ignored on advance cycles.
- R6: When `ld_n`=1, the address low two bits step by +1 modulo 4 and the upper bits are held. The direction of the loaded access continues, and `wr_n` and `addr` are ignored.
- R7: While `cken_n`=1, the edge has no effect. No access is captured, no write happens and the outputs hold. The pipeline resumes unchanged afterwards.
- R8: While `sleep`=1, every other input (including `cken_n`) is ignored, the outputs hold and the memory contents are preserved.
- R9: `oe_n`=1 forces `rdata` to zero at once, without clocking, and changes neither `rvalid` nor the pipeline.
- R10: A read loaded right after a write to the same address returns the new data. A write loaded right after a read of the same address does not disturb the data that read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cken_n | input | 1 | Active-low clock enable; high stalls everything |
| sleep | input | 1 | High freezes the block and ignores other inputs |
| ld_n | input | 1 | Low loads a new access, high advances the burst |
| wr_n | input | 1 | Low writes, high reads; sampled on loads only |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Active-low lane write enables |
| cs_n_a | input | 1 | Active-low chip select |
| cs_n_b | input | 1 | Active-low chip select |
| cs_h | input | 1 | Active-high chip select |
| oe_n | input | 1 | Asynchronous active-low read data gate |
| wdata | input | LANES*LANE_W | Write data, two enabled edges after its address |
| rdata | output | LANES*LANE_W | Read data, zero when gated or not valid |
| rvalid | output | 1 | High while rdata holds a completed read |

## Verification
The hardest case to reach is a stall or sleep that lands in the middle of a burst while a write's data phase is still in flight. The bus then carries junk that must not be stored. The pipeline must also pick up exactly where it stopped. The bench gets there by loading a four-beat write burst with its start at word 2, so that it wraps. It holds `cken_n` high for several cycles between beats, and later holds `sleep` high with `cken_n` low. During both holds it drives random address, direction and data values. It then reads the whole group back and compares it with its own model array.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n,
  input  logic              sleep,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic              cs_n_a,
  input  logic              cs_n_b,
  input  logic              cs_h,
  input  logic              oe_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  typedef struct packed {
    logic              act;
    logic              wr;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  be;
  } op_t;

  op_t p1, p2, nxt;
  logic [DW-1:0] rd_word, rdata_q;
  logic rvalid_q;

  wire en = !cken_n && !sleep;

  always_comb begin
    nxt = p1;
    if (!ld_n) begin
      nxt.act = !cs_n_a && !cs_n_b && cs_h;
      nxt.wr  = !wr_n;
      nxt.a   = addr;
      nxt.be  = ~bw_n;
    end else begin
      nxt.a[1:0] = p1.a[1:0] + 2'd1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (en && p2.act && p2.wr && p2.be[g])
        mem[p2.a] <= wdata[g*LANE_W +: LANE_W];
    assign rd_word[g*LANE_W +: LANE_W] = mem[p2.a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1       <= '0;
      p2       <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (en) begin
      p1       <= nxt;
      p2       <= p1;
      rvalid_q <= p2.act && !p2.wr;
      if (p2.act && !p2.wr) rdata_q <= rd_word;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = (!oe_n && rvalid_q) ? rdata_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cken_n,
  input logic          sleep,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !rvalid);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cken_n && !sleep) |=> $stable(rvalid));

  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(rvalid));

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> rdata == '0);

  a_r2_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(!cken_n && !sleep));

endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sleep(sleep),
  .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 6, DW = 18;

  logic clk = 0, rst_n = 0, cken_n = 0, sleep = 0, ld_n = 0, wr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [1:0] bw_n = 2'b11;
  logic cs_n_a = 1, cs_n_b = 1, cs_h = 0, oe_n = 0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid;

  zbt_sram i_zbt_sram (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [64];
  logic          ev [2];
  logic [DW-1:0] ed [2];
  logic [DW-1:0] wq [2];
  logic [AW-1:0] b_a;
  logic b_wr, b_sel;
  logic [1:0] b_be;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit ld, input bit wr, input logic [AW-1:0] a,
                      input logic [1:0] be, input bit sel_a, input bit sel_b, input bit sel_h,
                      input logic [DW-1:0] d);
    logic nv;
    logic [DW-1:0] nd;
    if (ld) begin
      b_a = a; b_wr = wr; b_be = be; b_sel = !sel_a && !sel_b && sel_h;
    end else b_a[1:0] = b_a[1:0] + 2'd1;
    nv = b_sel && !b_wr;
    nd = nv ? ref_mem[b_a] : '0;
    if (b_sel && b_wr) begin
      if (b_be[0]) ref_mem[b_a][8:0]  = d[8:0];
      if (b_be[1]) ref_mem[b_a][17:9] = d[17:9];
    end
    ld_n = !ld; wr_n = !wr; addr = a; bw_n = ~be;
    cs_n_a = sel_a; cs_n_b = sel_b; cs_h = sel_h;
    wdata = wq[1]; wq[1] = wq[0]; wq[0] = d;
    @(posedge clk); @(negedge clk);
    check(req, {17'd0, rvalid}, {17'd0, ev[1]});
    check(req, rdata, ed[1]);
    ev[1] = ev[0]; ed[1] = ed[0]; ev[0] = nv; ed[0] = nd;
  endtask

  task automatic wr_ld(string r, logic [AW-1:0] a, logic [1:0] be, logic [DW-1:0] d);
    step(r, 1, 1, a, be, 0, 0, 1, d);
  endtask
  task automatic rd_ld(string r, logic [AW-1:0] a);
    step(r, 1, 0, a, 2'b11, 0, 0, 1, '0);
  endtask
  task automatic adv(string r, logic [DW-1:0] d);
    step(r, 0, $urandom_range(1), AW'($urandom), 2'($urandom), 1, 1, 0, d);
  endtask
  task automatic idle(string r);
    step(r, 1, 0, '0, 2'b11, 1, 1, 0, '0);
  endtask

  task automatic hold(string r, bit use_sleep, int n);
    logic v0;
    logic [DW-1:0] d0;
    v0 = rvalid; d0 = rdata;
    cken_n = !use_sleep; sleep = use_sleep;
    for (int i = 0; i < n; i++) begin
      ld_n = $urandom_range(1); wr_n = $urandom_range(1); addr = AW'($urandom);
      wdata = DW'($urandom); bw_n = 2'($urandom); cs_n_a = 0; cs_n_b = 0; cs_h = 1;
      if (use_sleep) cken_n = 0;
      @(posedge clk); @(negedge clk);
      check(r, {17'd0, rvalid}, {17'd0, v0});
      check(r, rdata, d0);
    end
    cken_n = 0; sleep = 0;
  endtask

  task automatic t_reset;
    check("R1", {17'd0, rvalid}, 18'd0);
    check("R1", rdata, 18'd0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 4; i++) wr_ld("R3", AW'(8 + i), 2'b11, DW'(18'h1000 + i * 18'h111));
    for (int i = 0; i < 4; i++) rd_ld("R2", AW'(8 + i));
    idle("R2"); idle("R2");
  endtask

  task automatic t_raw_war;
    wr_ld("R10", 6'd20, 2'b11, 18'h2abcd);
    rd_ld("R10", 6'd20);
    wr_ld("R10", 6'd20, 2'b11, 18'h15555);
    rd_ld("R10", 6'd20);
    idle("R10"); idle("R10");
  endtask

  task automatic t_partial;
    wr_ld("R4", 6'd30, 2'b11, 18'h3ffff);
    wr_ld("R4", 6'd30, 2'b01, 18'h00012);
    wr_ld("R4", 6'd31, 2'b11, 18'h00000);
    wr_ld("R4", 6'd31, 2'b10, 18'h2aa00);
    rd_ld("R4", 6'd30); rd_ld("R4", 6'd31);
    idle("R4"); idle("R4");
  endtask

  task automatic t_deselect;
    step("R5", 1, 1, 6'd40, 2'b11, 1, 0, 1, 18'h11111);
    step("R5", 1, 1, 6'd40, 2'b11, 0, 1, 1, 18'h22222);
    step("R5", 1, 1, 6'd40, 2'b11, 0, 0, 0, 18'h33333);
    step("R5", 1, 0, 6'd40, 2'b11, 1, 1, 1, '0);
    adv("R5", '0);
    rd_ld("R5", 6'd40);
    idle("R5"); idle("R5");
  endtask

  task automatic t_burst;
    wr_ld("R6", 6'd50, 2'b11, 18'h0a0a0);
    adv("R6", 18'h0b0b1);
    hold("R7", 0, 3);
    adv("R6", 18'h0c0c2);
    adv("R6", 18'h0d0d3);
    hold("R8", 1, 4);
    step("R5", 1, 0, 6'd51, 2'b11, 0, 0, 1, '0);
    adv("R5", '0); adv("R6", '0);
    hold("R7", 0, 2);
    adv("R6", '0);
    idle("R6"); idle("R6");
  endtask

  task automatic t_oe;
    rd_ld("R9", 6'd50); idle("R9"); idle("R9");
    oe_n = 1; #1;
    check("R9", rdata, 18'd0);
    check("R9", {17'd0, rvalid}, 18'd1);
    oe_n = 0; #1;
    check("R9", rdata, ref_mem[50]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 'x;
    ev[0] = 0; ev[1] = 0; ed[0] = '0; ed[1] = '0; wq[0] = '0; wq[1] = '0;
    b_a = '0; b_wr = 0; b_sel = 0; b_be = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_raw_war;
    t_partial;
    t_deselect;
    t_burst;
    t_oe;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule